// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral guards a processor against runaway or stalled software. A 12-bit down-counter steps once per slow tick (256 ticks make one second). Software must restart the counter before it runs out. It must also wait until the count has fallen into a permitted window before restarting. An underflow or a restart that comes too early is a fault. Depending on configuration, a fault raises an interrupt that holds until software reads the status. It can also drive a fixed-length reset pulse, either to the whole system or to the processor alone.

Configuration lives in a mode register. Software may write it once after reset, and the register then locks. Restarts are requested through a control register, and a restart only counts if a key byte matches. A status register reports the two fault kinds and shows the live count. Two halt inputs, for idle and for debug, freeze the counter while they are asserted and their matching mode bit is set. A disable bit stops counting and faulting altogether.

The register port is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high, and is zero otherwise. The read-side effect of a status read, clearing the flags, happens at that same edge.

Top module: `winwdt_top`

## Requirements
- R1: After reset the mode register reads 0x3FFF2FFF, the status flags read 0, the count reads 0xFFF, and `fault_irq`, `sys_rst_out` and `cpu_rst_out` are low.
- R2: The first write to the mode register (byte address 0x4) after reset is stored and also loads the counter from bits 11:0 of the written data. Every later mode write is ignored, and the register keeps its value.
- R3: Mode fields: reload value in bits 11:0, window limit in bits 27:16, interrupt enable bit 12, reset enable bit 13, processor-only reset bit 14, disable bit 15, debug-halt enable bit 28, idle-halt enable bit 29.
- R4: Each `tick` decrements the counter by one. A tick while the count is 0 is an underflow fault and reloads the counter from the reload field.
- R5: A write to the control register (address 0x0) with 0xA5 in bits 31:24 and bit 0 set is a restart request. Any other key leaves the block unchanged. A restart while the count is at or below the window limit reloads the counter.
- R6: A restart request while the count is above the window limit is a window fault. It does not reload the counter, and a tick in the same cycle still applies.
- R7: The status register (address 0x8) shows the underflow flag in bit 0, the window flag in bit 1 and the count in bits 27:16. A status read clears both flags, except that a fault in the same cycle leaves its flag set. `bus_rdata` is 0 while `bus_rd` is low.
- R8: With the interrupt enable bit set, a fault raises `fault_irq` from the next cycle. It stays high until a status read.
- R9: With the reset enable bit set, a fault drives a 16-cycle pulse. The pulse goes on `cpu_rst_out` when processor-only reset is set, and on `sys_rst_out` otherwise. A new fault during a pulse restarts it at full length. The two outputs are never high together.
- R10: Ticks are ignored while `idle_in` is high with idle-halt enabled, or while `debug_in` is high with debug-halt enabled. Without the enable bit, a halt input has no effect.
- R11: With the disable bit set the counter never changes after the mode write, restarts are ignored, and no fault occurs.
- R12: When a legal restart and a tick fall in the same cycle, the restart wins: the counter reloads and no underflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle slow-tick enable (256 per second) |
| idle_in | input | 1 | Processor idle indication |
| debug_in | input | 1 | Debugger halt indication |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| fault_irq | output | 1 | Fault interrupt, held until status read |
| sys_rst_out | output | 1 | System reset pulse |
| cpu_rst_out | output | 1 | Processor-only reset pulse |

## Verification
Two collisions matter most. The first is a restart meeting a tick in the same cycle. The bench issues a keyed restart together with a tick both inside the window, where the restart must win, and above it, where the window fault fires and the tick still decrements. The second is a status read in the same cycle as a new fault. The bench reads status on the very tick that underflows and expects the read to return the old flags while the new flag survives the clear. A behavioural model in the bench predicts every output on every cycle, so any ordering error in these collisions shows up as a mismatch.

// File: rtl/winwdt_pkg.sv
package winwdt_pkg;
  localparam int CNT_W = 12;
  localparam int REG_W = 32;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_MODE = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;

  localparam int RELOAD_LSB = 0;
  localparam int LIMIT_LSB  = 16;
  localparam int B_IRQ_EN   = 12;
  localparam int B_RST_EN   = 13;
  localparam int B_CPU_ONLY = 14;
  localparam int B_OFF      = 15;
  localparam int B_DBG_HALT = 28;
  localparam int B_IDL_HALT = 29;

  localparam logic [REG_W-1:0] MODE_RST = 32'h3FFF_2FFF;

  typedef struct packed {
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] limit;
    logic             irq_en;
    logic             rst_en;
    logic             cpu_only;
    logic             off;
    logic             dbg_halt;
    logic             idle_halt;
  } wdt_cfg_t;

  function automatic wdt_cfg_t decode_mode(input logic [REG_W-1:0] m);
    wdt_cfg_t c;
    c.reload    = m[RELOAD_LSB +: CNT_W];
    c.limit     = m[LIMIT_LSB +: CNT_W];
    c.irq_en    = m[B_IRQ_EN];
    c.rst_en    = m[B_RST_EN];
    c.cpu_only  = m[B_CPU_ONLY];
    c.off       = m[B_OFF];
    c.dbg_halt  = m[B_DBG_HALT];
    c.idle_halt = m[B_IDL_HALT];
    return c;
  endfunction
endpackage

// File: rtl/winwdt_modereg.sv
module winwdt_modereg #(
  parameter int              W       = 32,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mode_q,
  output logic         lock_q,
  output logic         accept
);
  assign accept = wr && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_VAL;
      lock_q <= 1'b0;
    end else if (accept) begin
      mode_q <= wdata;
      lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/winwdt_counter.sv
module winwdt_counter #(
  parameter int           W       = 12,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         halt,
  input  logic         off,
  input  logic         restart,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] limit,
  output logic [W-1:0] cnt_q,
  output logic         uf,
  output logic         win_err
);
  logic early, restart_ok, step;

  assign early      = cnt_q > limit;
  assign win_err    = restart && !off && early;
  assign restart_ok = restart && !off && !early;
  assign step       = tick && !halt && !off && !load && !restart_ok;
  assign uf         = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= RST_VAL;
    else if (load)       cnt_q <= load_val;
    else if (restart_ok) cnt_q <= reload;
    else if (step)       cnt_q <= uf ? reload : cnt_q - 1'b1;
  end
endmodule

// File: rtl/winwdt_status.sv
module winwdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic uf,
  input  logic win_err,
  input  logic clr,
  input  logic irq_en,
  output logic uf_flag,
  output logic we_flag,
  output logic irq
);
  logic fault;
  assign fault = uf || win_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_flag <= 1'b0;
      we_flag <= 1'b0;
      irq     <= 1'b0;
    end else begin
      uf_flag <= uf || (uf_flag && !clr);
      we_flag <= win_err || (we_flag && !clr);
      irq     <= (fault && irq_en) || (irq && !clr);
    end
  end
endmodule

// File: rtl/winwdt_rstgen.sv
module winwdt_rstgen #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic cpu_sel,
  output logic sys_rst,
  output logic cpu_rst
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q;
  logic          tgt_q;
  logic          busy;

  assign busy    = left_q != '0;
  assign sys_rst = busy && !tgt_q;
  assign cpu_rst = busy && tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      tgt_q  <= 1'b0;
    end else if (fire) begin
      left_q <= CW'(LEN);
      tgt_q  <= cpu_sel;
    end else if (busy) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/winwdt_top.sv
module winwdt_top
  import winwdt_pkg::*;
#(
  parameter logic [7:0] KEY       = 8'hA5,
  parameter int         PULSE_LEN = 16,
  parameter int         ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              idle_in,
  input  logic              debug_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              fault_irq,
  output logic              sys_rst_out,
  output logic              cpu_rst_out
);
  localparam int PAD_HI = REG_W - LIMIT_LSB - CNT_W;
  localparam int PAD_LO = LIMIT_LSB - 2;

  logic [1:0]       sel;
  logic [REG_W-1:0] mode_q;
  logic             lock_q, mode_wr, mode_ld;
  logic             restart_req, stat_rd, halt_req;
  logic [CNT_W-1:0] cnt_q;
  logic             uf, win_err, fault_any;
  logic             uf_flag, we_flag;
  wdt_cfg_t         cfg;
  logic             unused_addr;

  assign sel         = bus_addr[3:2];
  assign unused_addr = ^bus_addr[1:0];
  assign mode_wr     = bus_wr && (sel == SEL_MODE);
  assign stat_rd     = bus_rd && (sel == SEL_STAT);
  assign restart_req = bus_wr && (sel == SEL_CTRL) &&
                       (bus_wdata[REG_W-1 -: 8] == KEY) && bus_wdata[0];
  assign cfg         = decode_mode(mode_q);
  assign halt_req    = (idle_in && cfg.idle_halt) || (debug_in && cfg.dbg_halt);
  assign fault_any   = uf || win_err;

  winwdt_modereg #(.W(REG_W), .RST_VAL(MODE_RST)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wdata(bus_wdata),
    .mode_q(mode_q), .lock_q(lock_q), .accept(mode_ld)
  );

  winwdt_counter #(.W(CNT_W), .RST_VAL(MODE_RST[RELOAD_LSB +: CNT_W])) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .halt(halt_req), .off(cfg.off),
    .restart(restart_req), .load(mode_ld),
    .load_val(bus_wdata[RELOAD_LSB +: CNT_W]),
    .reload(cfg.reload), .limit(cfg.limit),
    .cnt_q(cnt_q), .uf(uf), .win_err(win_err)
  );

  winwdt_status u_stat (
    .clk(clk), .rst_n(rst_n), .uf(uf), .win_err(win_err), .clr(stat_rd),
    .irq_en(cfg.irq_en), .uf_flag(uf_flag), .we_flag(we_flag), .irq(fault_irq)
  );

  winwdt_rstgen #(.LEN(PULSE_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(fault_any && cfg.rst_en),
    .cpu_sel(cfg.cpu_only), .sys_rst(sys_rst_out), .cpu_rst(cpu_rst_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (sel)
        SEL_MODE: bus_rdata = mode_q;
        SEL_STAT: bus_rdata = {{PAD_HI{1'b0}}, cnt_q, {PAD_LO{1'b0}}, we_flag, uf_flag};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/winwdt_sva.sv
module winwdt_sva
  import winwdt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             fault_irq,
  input logic             sys_rst_out,
  input logic             cpu_rst_out,
  input logic [REG_W-1:0] mode_q,
  input logic             lock_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             restart_req,
  input logic             mode_wr,
  input logic             halt_req,
  input logic             stat_rd,
  input logic             fault_any,
  input logic             uf_flag,
  input logic             we_flag
);
  p_rst_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_rst_out && cpu_rst_out));

  p_pulse_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_out) |=> sys_rst_out);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq && !stat_rd |=> fault_irq);

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_irq) |-> $past(fault_any && mode_q[B_IRQ_EN]));

  p_mode_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mode_q));

  p_off_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && mode_q[B_OFF] |=> $stable(cnt_q));

  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && !restart_req && !mode_wr |=> $stable(cnt_q));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !fault_any |=> !uf_flag && !we_flag);
endmodule

bind winwdt_top winwdt_sva u_sva (
  .clk(clk), .rst_n(rst_n), .fault_irq(fault_irq), .sys_rst_out(sys_rst_out),
  .cpu_rst_out(cpu_rst_out), .mode_q(mode_q), .lock_q(lock_q), .cnt_q(cnt_q),
  .restart_req(restart_req), .mode_wr(mode_wr), .halt_req(halt_req),
  .stat_rd(stat_rd), .fault_any(fault_any), .uf_flag(uf_flag), .we_flag(we_flag)
);

// File: tb/winwdt_tb.sv
module winwdt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, idle_in = 1'b0, debug_in = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fault_irq, sys_rst_out, cpu_rst_out;

  int    tests = 0, fails = 0, cyc = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  winwdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .idle_in(idle_in), .debug_in(debug_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fault_irq(fault_irq), .sys_rst_out(sys_rst_out),
    .cpu_rst_out(cpu_rst_out)
  );

  // Behavioural reference model
  logic [31:0] m_mode;
  bit          m_lock, m_uf, m_we, m_irq, m_tgt;
  int          m_cnt, m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 32'h3FFF_2FFF; m_lock = 0; m_cnt = 'hFFF;
      m_uf = 0; m_we = 0; m_irq = 0; m_left = 0; m_tgt = 0;
    end else begin
      automatic int  reload  = int'(m_mode[11:0]);
      automatic int  limit   = int'(m_mode[27:16]);
      automatic bit  off     = m_mode[15];
      automatic bit  halted  = (idle_in && m_mode[29]) || (debug_in && m_mode[28]);
      automatic bit  restart = bus_wr && bus_addr[3:2] == 0 && bus_wdata[31:24] == 8'hA5 && bus_wdata[0];
      automatic bit  modew   = bus_wr && bus_addr[3:2] == 1 && !m_lock;
      automatic bit  rdclr   = bus_rd && bus_addr[3:2] == 2;
      automatic bit  uf = 0, we = 0;
      if (!off && restart && m_cnt > limit) we = 1;
      if (modew) begin
        m_cnt = int'(bus_wdata[11:0]); m_mode = bus_wdata; m_lock = 1;
      end else if (!off) begin
        if (restart && !we) m_cnt = reload;
        else if (tick && !halted) begin
          if (m_cnt == 0) begin uf = 1; m_cnt = reload; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (uf) m_uf = 1; else if (rdclr) m_uf = 0;
      if (we) m_we = 1; else if (rdclr) m_we = 0;
      if ((uf || we) && m_mode[12] && !modew) m_irq = 1; else if (rdclr) m_irq = 0;
      if ((uf || we) && m_mode[13]) begin m_left = 16; m_tgt = m_mode[14]; end
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      automatic logic [31:0] exp_rd = '0;
      if (bus_rd) begin
        if (bus_addr[3:2] == 1) exp_rd = m_mode;
        else if (bus_addr[3:2] == 2) exp_rd = {4'h0, 12'(m_cnt), 14'h0, m_we, m_uf};
      end
      chk(bus_rdata === exp_rd, "rdata", bus_rdata, exp_rd);
      chk(fault_irq === m_irq, "fault_irq (R8)", 32'(fault_irq), 32'(m_irq));
      chk(sys_rst_out === (m_left > 0 && !m_tgt), "sys_rst_out (R9)", 32'(sys_rst_out), 32'(m_left > 0 && !m_tgt));
      chk(cpu_rst_out === (m_left > 0 && m_tgt), "cpu_rst_out (R9)", 32'(cpu_rst_out), 32'(m_left > 0 && m_tgt));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++;
      $display("FAIL [watchdog] run hung actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic drive(input logic t, input logic w, input logic r, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    tick = t; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1, 0, 0, 4'h0, '0);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 4'h0, '0);
  endtask

  task automatic rd_stat(); drive(0, 0, 1, 4'h8, '0); endtask
  task automatic rd_mode(); drive(0, 0, 1, 4'h4, '0); endtask
  task automatic restart(); drive(0, 1, 0, 4'h0, 32'hA500_0001); endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; tick = 0; bus_wr = 0; bus_rd = 0; idle_in = 0; debug_in = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // R1: reset values
    tag = "R1"; rd_mode(); rd_stat(); nop(2);
    // R5: wrong key ignored, right key reloads
    tag = "R5"; ticks(5); drive(0, 1, 0, 4'h0, 32'h5A00_0001); rd_stat();
    drive(0, 1, 0, 4'h0, 32'hA500_0000); rd_stat(); restart(); rd_stat();
    // R4: count down to underflow under default mode, system reset pulse
    tag = "R4"; ticks(4100); rd_stat();
    tag = "R9"; nop(20); rd_stat();

    // Second configuration: reload 40, window 10, interrupt only
    do_reset();
    tag = "R2"; drive(0, 1, 0, 4'h4, 32'h000A_1028); rd_mode(); rd_stat();
    drive(0, 1, 0, 4'h4, 32'hFFFF_FFFF); rd_mode(); rd_stat();
    tag = "R3"; ticks(5); rd_stat();
    tag = "R6"; restart(); rd_stat(); ticks(3);
    tag = "R8"; drive(1, 1, 0, 4'h0, 32'hA500_0001); nop(5); rd_stat(); nop(3);
    tag = "R5"; ticks(25); rd_stat(); restart(); rd_stat();
    tag = "R12"; ticks(35); rd_stat(); drive(1, 1, 0, 4'h0, 32'hA500_0001); rd_stat();
    tag = "R7"; ticks(40); drive(1, 0, 1, 4'h8, '0); rd_stat(); rd_stat(); nop(2);

    // Third configuration: halts enabled, processor-only reset
    do_reset();
    tag = "R10"; drive(0, 1, 0, 4'h4, 32'h3014_6014);
    idle_in = 1; ticks(10); rd_stat(); idle_in = 0; debug_in = 1; ticks(10); rd_stat();
    debug_in = 0; ticks(8); rd_stat();
    tag = "R9"; ticks(15); nop(3); ticks(10); nop(20); rd_stat();

    // Fourth configuration: disabled
    do_reset();
    tag = "R11"; drive(0, 1, 0, 4'h4, 32'h000A_B028); ticks(100); restart(); rd_stat(); nop(3);

    // Fifth configuration: halt inputs without enable bits, window 0
    do_reset();
    tag = "R10"; drive(0, 1, 0, 4'h4, 32'h0000_2010); idle_in = 1; debug_in = 1;
    ticks(6); rd_stat();
    tag = "R6"; restart(); nop(5); restart(); nop(20); rd_stat();
    tag = "R4"; ticks(20); nop(20); rd_stat();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule